// File: doc/BRIEF.md
# Programmable Down-Counting Interrupt Timer

This block is a local timer that counts down from a programmed start value and, when it runs out, raises an interrupt request. The request is described by a packed 32-bit control word. The word carries an 8-bit vector, a 3-bit delivery mode, a trigger-type bit, a mask bit and a repeat bit. Software writes the control word and the start value through two simple write ports. It can read back both of them and the live count at any time.

Each cycle where `tick` is high counts as one step. A count that moves from 1 to 0 is an expiry. On expiry the block emits a one-clock request carrying the vector, delivery mode and level flag, unless the control word is masked. In repeat mode the live count is refilled from the start value on that same edge, masked or not. Otherwise the timer halts at zero. The request register that receives the strobe, and the bus that carries the register accesses, sit outside this block.

Top module: `lvt_timer`

## Requirements
- R1: Reset gives a control word of 0x0001_0000 (mask set, all else clear), a start value of 0, a live count of 0, a stopped timer and no request.
- R2: The control word holds vector in bits 7:0, delivery mode in bits 10:8, polarity in bit 13, trigger type in bit 15 (1 = level), mask in bit 16 and repeat in bit 17. A write stores the write data ANDed with 0x0003_A7FF. Bits 11, 12, 14 and 31:18 always read 0.
- R3: Writing a nonzero start value loads it into the live count and starts the timer. Writing zero clears the live count and stops the timer. The start value reads back as written.
- R4: Each tick while running lowers the live count by exactly one. Ticks while stopped change nothing.
- R5: An expiry is the tick that takes the live count from 1 to 0. When the mask bit is 0, `req_valid` is high for exactly the next cycle. In that cycle `req_vector` is bits 7:0, `req_mode` is bits 10:8 and `req_level` is bit 15 of the control word.
- R6: An expiry with the mask bit at 1 produces no request.
- R7: An expiry with the repeat bit at 1 reloads the live count with the start value on the same edge, whether or not the word is masked. With a start value of 1 this yields an expiry on every tick.
- R8: An expiry with the repeat bit at 0 leaves the live count at 0 and stops the timer, so no further requests follow.
- R9: A start-value write in the same cycle as a tick wins. The tick is ignored and no expiry happens in that cycle.
- R10: When a control-word write coincides with an expiry, the request uses the control word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable step |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 32 | Control-word write data |
| ctl_rdata | output | 32 | Control-word readback |
| init_wr | input | 1 | Start-value write strobe |
| init_wdata | input | CNT_W | Start-value write data |
| init_rdata | output | CNT_W | Start-value readback |
| cur_count | output | CNT_W | Live count |
| req_valid | output | 1 | One-clock interrupt request strobe |
| req_vector | output | 8 | Request vector |
| req_mode | output | 3 | Request delivery mode |
| req_level | output | 1 | Request is level-triggered |

## Verification
The assertions assume that reset is held for at least one clock before checks are meaningful. They also assume that every input is steady across the rising edge, with `tick`, `ctl_wr` and `init_wr` treated as independent per-cycle strobes that may coincide in any mix. The bench changes inputs only on falling edges. It deliberately drives the coincident cases: a start-value write on a tick, a control-word write on an expiry, and a start value of 1 in repeat mode so that expiries are back to back. A behavioural model compares every output on every clock.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    localparam int unsigned CTL_W = 32;

    // Bits that software may change in the control word.
    localparam logic [CTL_W-1:0] CTL_WMASK = 32'h0003_A7FF;
    // Reset image of the control word: only the mask bit set.
    localparam logic [CTL_W-1:0] CTL_RESET = 32'h0001_0000;

    typedef struct packed {
        logic [13:0] rsv_hi;
        logic        repeat_en;
        logic        masked;
        logic        level;
        logic        rsv_rirr;
        logic        polarity;
        logic        rsv_status;
        logic        rsv_b11;
        logic [2:0]  mode;
        logic [7:0]  vector;
    } ctl_word_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       level;
    } req_t;

    function automatic ctl_word_t ctl_sanitize(input logic [CTL_W-1:0] raw);
        return ctl_word_t'(raw & CTL_WMASK);
    endfunction

    function automatic req_t ctl_to_req(input ctl_word_t c);
        req_t r;
        r.vector = c.vector;
        r.mode   = c.mode;
        r.level  = c.level;
        return r;
    endfunction

endpackage

// File: rtl/lvt_ctl_reg.sv
module lvt_ctl_reg
    import lvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_word_t        ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= ctl_word_t'(CTL_RESET);
        end else if (wr) begin
            ctl <= ctl_sanitize(wdata);
        end
    end

    // R2: a write lands with only writable bits
    a_r2_write_masked: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl == ctl_word_t'($past(wdata) & CTL_WMASK)));

    // R2: fixed-zero bits never set
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl.rsv_hi == '0) && !ctl.rsv_status && !ctl.rsv_rirr && !ctl.rsv_b11);

endmodule

// File: rtl/lvt_down_counter.sv
module lvt_down_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             repeat_en,
    output logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    assign step   = tick && running && !load;
    assign expire = step && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            init_val <= '0;
            count    <= '0;
            running  <= 1'b0;
        end else if (load) begin
            init_val <= load_val;
            count    <= load_val;
            running  <= (load_val != '0);
        end else if (expire) begin
            if (repeat_en) begin
                count <= init_val;
            end else begin
                count   <= '0;
                running <= 1'b0;
            end
        end else if (step) begin
            count <= count - ONE;
        end
    end

    // R4: ordinary step lowers count by one
    a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick && running && !load && count > ONE) |=> (count == $past(count) - ONE));

    // R4: stopped timer holds its count
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !load) |=> $stable(count) && !running);

    // R8: one-shot expiry halts at zero
    a_r8_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
        (expire && !repeat_en) |=> (!running && count == '0));

    // R7: repeat expiry refills from start value
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && repeat_en) |=> (running && count == $past(init_val)));

    // R3: zero write stops the timer
    a_r3_zero_stop: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> (!running && count == '0));

endmodule

// File: rtl/lvt_req_gen.sv
module lvt_req_gen
    import lvt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      expire,
    input  ctl_word_t ctl,
    output logic      valid,
    output req_t      req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            req   <= '0;
        end else begin
            valid <= expire && !ctl.masked;
            if (expire && !ctl.masked) begin
                req <= ctl_to_req(ctl);
            end
        end
    end

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
    import lvt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic [31:0]      ctl_wdata,
    output logic [31:0]      ctl_rdata,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_wdata,
    output logic [CNT_W-1:0] init_rdata,
    output logic [CNT_W-1:0] cur_count,
    output logic             req_valid,
    output logic [7:0]       req_vector,
    output logic [2:0]       req_mode,
    output logic             req_level
);

    ctl_word_t ctl;
    req_t      req;
    logic      running;
    logic      expire;

    lvt_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    lvt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (init_wr),
        .load_val  (init_wdata),
        .repeat_en (ctl.repeat_en),
        .init_val  (init_rdata),
        .count     (cur_count),
        .running   (running),
        .expire    (expire)
    );

    lvt_req_gen u_req (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .ctl    (ctl),
        .valid  (req_valid),
        .req    (req)
    );

    assign ctl_rdata  = 32'(ctl);
    assign req_vector = req.vector;
    assign req_mode   = req.mode;
    assign req_level  = req.level;

    // R5 and R10: unmasked expiry yields a request built from the pre-write word
    a_r5_unmasked_fires: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctl.masked) |=> (req_valid && req_vector == $past(ctl.vector)
                                     && req_mode == $past(ctl.mode)
                                     && req_level == $past(ctl.level)));

    // R6: masked expiry stays silent
    a_r6_masked_silent: assert property (@(posedge clk) disable iff (rst)
        (expire && ctl.masked) |=> !req_valid);

    // R5: no request without an expiry
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !expire |=> !req_valid);

    // R9: start-value write beats a coincident tick
    a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
        (init_wr && tick) |=> (cur_count == $past(init_wdata) && !req_valid));

endmodule

// File: tb/test_lvt_timer.sv
module test_lvt_timer;

    localparam int CNT_W = 32;
    localparam logic [31:0] WMASK = 32'h0003_A7FF;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [31:0]      ctl_wdata = '0;
    logic [31:0]      ctl_rdata;
    logic             init_wr = 1'b0;
    logic [CNT_W-1:0] init_wdata = '0;
    logic [CNT_W-1:0] init_rdata;
    logic [CNT_W-1:0] cur_count;
    logic             req_valid;
    logic [7:0]       req_vector;
    logic [2:0]       req_mode;
    logic             req_level;

    always #2.5 clk = ~clk;

    lvt_timer #(.CNT_W(CNT_W)) i_lvt_timer (
        .clk(clk), .rst(rst), .tick(tick),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .init_wr(init_wr), .init_wdata(init_wdata), .init_rdata(init_rdata),
        .cur_count(cur_count), .req_valid(req_valid), .req_vector(req_vector),
        .req_mode(req_mode), .req_level(req_level)
    );

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int cycles = 0;

    // behavioural reference state
    logic [31:0]      m_ctl;
    logic [CNT_W-1:0] m_init;
    longint           m_cnt;
    bit               m_run;
    bit               m_v;
    logic [7:0]       m_vec;
    logic [2:0]       m_mode;
    bit               m_lvl;

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_ctl = 32'h0001_0000; m_init = '0; m_cnt = 0; m_run = 0;
            m_v = 0; m_vec = '0; m_mode = '0; m_lvl = 0;
        end else begin
            m_v = 0;
            if (!init_wr && tick && m_run && m_cnt == 1 && !m_ctl[16]) begin
                m_v = 1; m_vec = m_ctl[7:0]; m_mode = m_ctl[10:8]; m_lvl = m_ctl[15];
            end
            if (init_wr) begin
                m_init = init_wdata; m_cnt = init_wdata; m_run = (init_wdata != 0);
            end else if (tick && m_run) begin
                if (m_cnt == 1) begin
                    if (m_ctl[17]) m_cnt = m_init;
                    else begin m_cnt = 0; m_run = 0; end
                end else m_cnt = m_cnt - 1;
            end
            if (ctl_wr) m_ctl = ctl_wdata & WMASK;
        end
    end

    // compare every clock, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R2 ctl_rdata", ctl_rdata, m_ctl);
            check("R3 init_rdata", init_rdata, m_init);
            check("R4 cur_count", cur_count, m_cnt);
            check("R5 req_valid", req_valid, m_v);
            if (m_v) begin
                check("R5 req_vector", req_vector, m_vec);
                check("R5 req_mode", req_mode, m_mode);
                check("R5 req_level", req_level, m_lvl);
            end
            if (req_valid) pulses++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 0; ctl_wr = 0; init_wr = 0;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1; ctl_wr = 0; init_wr = 0;
        end
        @(negedge clk);
        tick = 0;
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        @(negedge clk);
        tick = 0; init_wr = 0; ctl_wr = 1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic wr_init(input logic [CNT_W-1:0] d);
        @(negedge clk);
        tick = 0; ctl_wr = 0; init_wr = 1; init_wdata = d;
        @(negedge clk);
        init_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset image
        check("R1 ctl reset", ctl_rdata, 32'h0001_0000);
        check("R1 count reset", cur_count, 0);
        check("R1 no request", req_valid, 0);

        // R4: ticks on a stopped timer do nothing
        ticks(4);
        check("R4 idle count", cur_count, 0);

        // R2: all-ones write keeps only writable bits
        wr_ctl(32'hFFFF_FFFF);
        check("R2 writable mask", ctl_rdata, 32'h0003_A7FF);

        // R5 and R8: one-shot, unmasked, edge
        wr_ctl(32'h0000_0141);
        wr_init(3);
        p0 = pulses;
        ticks(6);
        idle(1);
        check("R8 oneshot single request", pulses - p0, 1);
        check("R8 oneshot halted", cur_count, 0);

        // R6 and R7: masked repeat still reloads
        wr_ctl(32'h0003_0022);
        wr_init(2);
        p0 = pulses;
        ticks(6);
        idle(1);
        check("R6 masked no request", pulses - p0, 0);
        check("R7 masked reload count", cur_count, 2);

        // R7: unmasked repeat, level, mode 4
        wr_ctl(32'h0002_8490);
        wr_init(2);
        p0 = pulses;
        ticks(6);
        idle(1);
        check("R7 repeat requests", pulses - p0, 3);

        // R7: start value 1 in repeat mode fires every tick
        wr_init(1);
        p0 = pulses;
        ticks(4);
        idle(1);
        check("R7 back-to-back", pulses - p0, 4);

        // R3: zero write stops
        wr_init(0);
        ticks(3);
        check("R3 zero stops", cur_count, 0);

        // R9: start write coincides with expiring tick
        wr_init(1);
        @(negedge clk);
        tick = 1; init_wr = 1; init_wdata = 5;
        @(negedge clk);
        tick = 0; init_wr = 0;
        check("R9 load wins", cur_count, 5);
        check("R9 no expiry", req_valid, 0);

        // R10: control write on the expiring tick uses the old word
        wr_ctl(32'h0000_0233);
        wr_init(1);
        @(negedge clk);
        tick = 1; ctl_wr = 1; ctl_wdata = 32'h0001_0077;
        @(negedge clk);
        tick = 0; ctl_wr = 0;
        check("R10 old word used", req_vector, 8'h33);
        check("R10 request seen", req_valid, 1);

        // R4: sparse ticks on a long count
        wr_ctl(32'h0000_0010);
        wr_init(40);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            tick = (k % 3 != 1);
        end
        idle(2);
        check("R4 sparse count", cur_count, 20);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 re-reset count", cur_count, 0);
        check("R1 re-reset ctl", ctl_rdata, 32'h0001_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule